// File: doc/BRIEF.md
# Even/Odd FIFO Hash Host Interface

This block sits between a host that delivers message data as 32-bit words and a set of selectable hash cores. Some cores take 32-bit words and some take 64-bit words. Each inbound host word goes into one of two 32-bit FIFOs. The FIFOs alternate from one write to the next and start with the even FIFO after reset. A core that takes 64-bit words pops both FIFOs at once. A core that takes 32-bit words pops them in turn, even then odd, so it receives the words in the order the host wrote them.

The host starts a hash by pulsing a start strobe with a core index. The index is latched only while no hash is running. Only the latched core gets its clock enable, and only while the hash runs. A request output tells the host that the inbound storage is nearly drained. The core writes its digest into an eight-word result buffer and then signals completion. Completion raises an acknowledge output, and the host reads the digest back word by word. With the default depth of 252 words per FIFO, the two FIFOs together hold 2016 bytes. The result buffer holds 32 bytes.

Top module: `hash_host_if`

## Requirements
- R1: After reset, `host_req` is 1, `host_ack` is 0, `core_en` is all zero, `core_valid` is 0 and every result word reads as zero.
- R2: Accepted host writes go to the even FIFO first and then alternate between odd and even. A 32-bit core therefore pops the words in write order, and each word appears on `core_data[31:0]` with `core_data[63:32]` equal to zero.
- R3: When the selected core is wide, `core_data` is {odd head, even head}, with the odd word in bits 63:32 and the even word in bits 31:0. `core_valid` needs both FIFOs to be non-empty, and one pop removes one word from each FIFO.
- R4: When the selected core is narrow, `core_valid` is 1 exactly when the FIFO whose turn it is holds a word. Each pop moves the turn to the other FIFO.
- R5: `host_req` is 1 while the total number of words in both FIFOs is at most `AE_THRESH`, and 0 when the total is above it.
- R6: A host write aimed at a full FIFO is dropped, and the write turn does not advance.
- R7: A start with an index below `NCORES` while idle latches the index. `core_en` then has exactly bit [index] set until completion, and is all zero while idle.
- R8: A start while a hash runs, or a start with an index of `NCORES` or above, is ignored: the latched index, `core_en` and `host_ack` stay as they were.
- R9: `core_wide` equals bit [latched index] of the parameter `WIDE_MASK`.
- R10: `core_done` during a hash ends it. From the next cycle on, `host_ack` is 1 and `core_en` is zero. The next accepted start clears `host_ack`.
- R11: `core_res_we` during a hash stores `core_res_data` at `core_res_addr`, and `host_rd_data` shows the word at `host_rd_addr`. Result writes while idle are dropped.
- R12: `core_pop` while idle removes nothing from either FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wvalid | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write word |
| host_start | input | 1 | Start strobe |
| host_sel | input | SELW | Core index for the start strobe |
| host_req | output | 1 | Inbound storage nearly empty |
| host_ack | output | 1 | Digest available |
| host_rd_addr | input | RW | Result word index |
| host_rd_data | output | 32 | Result word |
| core_en | output | NCORES | Per-core clock enable |
| core_wide | output | 1 | Selected core takes 64-bit words |
| core_valid | output | 1 | Word available to the core |
| core_data | output | 64 | Word offered to the core |
| core_pop | input | 1 | Core consumes the offered word |
| core_res_we | input | 1 | Core result write strobe |
| core_res_addr | input | RW | Core result word index |
| core_res_data | input | 32 | Core result word |
| core_done | input | 1 | Core finished the hash |

## Verification
The bench builds the block with three cores, where core 1 is the only wide core. It uses FIFOs of four words each and an almost-empty threshold of three. With this shallow depth, the bench can fill both FIFOs within a few writes, which exercises the dropped write at a full FIFO and the write turn that must not advance. With a threshold of three, `host_req` can be seen switching between three and four stored words. Mixing one narrow core and one wide core lets the same write stream be checked both as an alternating 32-bit sequence and as packed 64-bit pairs, including a wide word held back while only its even half is present.

// File: rtl/hif_pkg.sv
package hif_pkg;

  typedef enum logic {
    SLOT_EVEN = 1'b0,
    SLOT_ODD  = 1'b1
  } slot_e;

  // Ring index advance for a storage of arbitrary depth.
  function automatic int unsigned next_idx(input int unsigned idx, input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // Occupancy test used for the host request line.
  function automatic logic at_or_below(input int unsigned occ, input int unsigned thr);
    return occ <= thr;
  endfunction

  function automatic slot_e flip(input slot_e s);
    return (s == SLOT_EVEN) ? SLOT_ODD : SLOT_EVEN;
  endfunction

endpackage

// File: rtl/hif_fifo.sv
module hif_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 252
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= PW'(hif_pkg::next_idx(32'(wr_ptr), DEPTH));
      if (do_pop)  rd_ptr <= PW'(hif_pkg::next_idx(32'(rd_ptr), DEPTH));
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hif_lane_steer.sv
module hif_lane_steer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wvalid,
  input  logic [1:0]  lane_full,
  input  logic [1:0]  lane_empty,
  input  logic [31:0] head_even,
  input  logic [31:0] head_odd,
  input  logic        wide,
  input  logic        pop_req,
  output logic [1:0]  lane_push,
  output logic [1:0]  lane_pop,
  output logic [63:0] rd_data,
  output logic        rd_valid,
  output logic        wr_turn
);
  import hif_pkg::*;

  slot_e wr_slot, rd_slot;
  logic  wr_ok, rd_fire;

  assign wr_turn = wr_slot;
  assign wr_ok   = host_wvalid && !lane_full[wr_slot];

  always_comb begin
    lane_push          = 2'b00;
    lane_push[wr_slot] = wr_ok;
  end

  always_comb begin
    if (wide) begin
      rd_valid = !lane_empty[0] && !lane_empty[1];
      rd_data  = {head_odd, head_even};
    end else begin
      rd_valid = !lane_empty[rd_slot];
      rd_data  = {32'h0, (rd_slot == SLOT_ODD) ? head_odd : head_even};
    end
  end

  assign rd_fire = pop_req && rd_valid;

  always_comb begin
    lane_pop = 2'b00;
    if (rd_fire) begin
      if (wide) lane_pop = 2'b11;
      else      lane_pop[rd_slot] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_slot <= SLOT_EVEN;
      rd_slot <= SLOT_EVEN;
    end else begin
      if (wr_ok) wr_slot <= flip(wr_slot);
      if (rd_fire && !wide) rd_slot <= flip(rd_slot);
    end
  end
endmodule

// File: rtl/hif_ctrl.sv
module hif_ctrl #(
  parameter int NCORES = 5,
  parameter int SELW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_start,
  input  logic [SELW-1:0] host_sel,
  input  logic            core_done,
  output logic [SELW-1:0] sel_q,
  output logic            busy,
  output logic            ack
);
  logic start_ok;

  assign start_ok = host_start && !busy && (int'(host_sel) < NCORES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      busy  <= 1'b0;
      ack   <= 1'b0;
    end else if (start_ok) begin
      sel_q <= host_sel;
      busy  <= 1'b1;
      ack   <= 1'b0;
    end else if (busy && core_done) begin
      busy <= 1'b0;
      ack  <= 1'b1;
    end
  end
endmodule

// File: rtl/hif_result_buf.sv
module hif_result_buf #(
  parameter int WORDS = 8,
  parameter int RW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [RW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] words [WORDS];

  assign rdata = words[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) words[i] <= '0;
    end else if (we) begin
      words[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/hash_host_if.sv
module hash_host_if #(
  parameter int              NCORES    = 5,
  parameter logic [NCORES-1:0] WIDE_MASK = 5'b01000,
  parameter int              DEPTH     = 252,
  parameter int              AE_THRESH = 4,
  parameter int              RES_WORDS = 8,
  localparam int             SELW      = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int             RW        = (RES_WORDS > 1) ? $clog2(RES_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wvalid,
  input  logic [31:0]       host_wdata,
  input  logic              host_start,
  input  logic [SELW-1:0]   host_sel,
  output logic              host_req,
  output logic              host_ack,
  input  logic [RW-1:0]     host_rd_addr,
  output logic [31:0]       host_rd_data,
  output logic [NCORES-1:0] core_en,
  output logic              core_wide,
  output logic              core_valid,
  output logic [63:0]       core_data,
  input  logic              core_pop,
  input  logic              core_res_we,
  input  logic [RW-1:0]     core_res_addr,
  input  logic [31:0]       core_res_data,
  input  logic              core_done
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int OCCW = CW + 1;

  logic [1:0]      lane_push, lane_pop, lane_full, lane_empty;
  logic [31:0]     lane_head [2];
  logic [CW-1:0]   lane_cnt  [2];
  logic [OCCW-1:0] occ_total;
  logic [SELW-1:0] sel_q;
  logic            busy, wr_turn, pop_req;
  logic [NCORES-1:0] wide_hit;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    hif_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (lane_push[g]),
      .wdata (host_wdata),
      .pop   (lane_pop[g]),
      .head  (lane_head[g]),
      .count (lane_cnt[g]),
      .full  (lane_full[g]),
      .empty (lane_empty[g])
    );
  end

  assign pop_req = core_pop && busy;

  hif_lane_steer u_steer (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wvalid (host_wvalid),
    .lane_full   (lane_full),
    .lane_empty  (lane_empty),
    .head_even   (lane_head[0]),
    .head_odd    (lane_head[1]),
    .wide        (core_wide),
    .pop_req     (pop_req),
    .lane_push   (lane_push),
    .lane_pop    (lane_pop),
    .rd_data     (core_data),
    .rd_valid    (core_valid),
    .wr_turn     (wr_turn)
  );

  hif_ctrl #(.NCORES(NCORES), .SELW(SELW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_start (host_start),
    .host_sel   (host_sel),
    .core_done  (core_done),
    .sel_q      (sel_q),
    .busy       (busy),
    .ack        (host_ack)
  );

  hif_result_buf #(.WORDS(RES_WORDS), .RW(RW)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (core_res_we && busy),
    .waddr (core_res_addr),
    .wdata (core_res_data),
    .raddr (host_rd_addr),
    .rdata (host_rd_data)
  );

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    assign core_en[c]  = busy && (sel_q == SELW'(c));
    assign wide_hit[c] = WIDE_MASK[c] && (sel_q == SELW'(c));
  end

  assign core_wide = |wide_hit;
  assign occ_total = OCCW'(lane_cnt[0]) + OCCW'(lane_cnt[1]);
  assign host_req  = hif_pkg::at_or_below(32'(occ_total), AE_THRESH);
endmodule

// File: rtl/hash_host_if_chk.sv
module hash_host_if_chk #(
  parameter int NCORES = 5,
  parameter int SELW   = 3,
  parameter int CW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCORES-1:0] core_en,
  input logic              core_done,
  input logic              busy,
  input logic              ack,
  input logic              host_start,
  input logic              host_wvalid,
  input logic [SELW-1:0]   sel_q,
  input logic              core_wide,
  input logic              core_valid,
  input logic [CW-1:0]     cnt_even,
  input logic [CW-1:0]     cnt_odd,
  input logic [1:0]        lane_pop,
  input logic [1:0]        lane_full,
  input logic              wr_turn
);
  // R7
  en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_en));

  // R10
  done_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && core_done) |=> (ack && core_en == '0));

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_start) |=> $stable(sel_q));

  // R3
  wide_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wide && core_valid) |-> (cnt_even != '0 && cnt_odd != '0));

  // R12
  idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lane_pop == 2'b00));

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wvalid && lane_full[wr_turn]) |=> $stable(wr_turn));

  // R2
  turn_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wvalid && !lane_full[wr_turn]) |=> (wr_turn != $past(wr_turn)));
endmodule

bind hash_host_if hash_host_if_chk #(
  .NCORES (NCORES),
  .SELW   (SELW),
  .CW     (CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_en     (core_en),
  .core_done   (core_done),
  .busy        (busy),
  .ack         (host_ack),
  .host_start  (host_start),
  .host_wvalid (host_wvalid),
  .sel_q       (sel_q),
  .core_wide   (core_wide),
  .core_valid  (core_valid),
  .cnt_even    (lane_cnt[0]),
  .cnt_odd     (lane_cnt[1]),
  .lane_pop    (lane_pop),
  .lane_full   (lane_full),
  .wr_turn     (wr_turn)
);

// File: tb/hash_host_if_bench.sv
module hash_host_if_bench;
  localparam int NC = 3;
  localparam int DP = 4;
  localparam int TH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wvalid = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        host_start = 1'b0;
  logic [1:0]  host_sel = '0;
  logic        host_req, host_ack;
  logic [2:0]  host_rd_addr = '0;
  logic [31:0] host_rd_data;
  logic [NC-1:0] core_en;
  logic        core_wide, core_valid;
  logic [63:0] core_data;
  logic        core_pop = 1'b0;
  logic        core_res_we = 1'b0;
  logic [2:0]  core_res_addr = '0;
  logic [31:0] core_res_data = '0;
  logic        core_done = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q [$];

  always #4 clk = ~clk;

  hash_host_if #(.NCORES(NC), .WIDE_MASK(3'b010), .DEPTH(DP), .AE_THRESH(TH), .RES_WORDS(8))
  u_hash_host_if (
    .clk(clk), .rst_n(rst_n), .host_wvalid(host_wvalid), .host_wdata(host_wdata),
    .host_start(host_start), .host_sel(host_sel), .host_req(host_req), .host_ack(host_ack),
    .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data), .core_en(core_en),
    .core_wide(core_wide), .core_valid(core_valid), .core_data(core_data),
    .core_pop(core_pop), .core_res_we(core_res_we), .core_res_addr(core_res_addr),
    .core_res_data(core_res_data), .core_done(core_done)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO-IF FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Driver: push the word and record it as expected if it should be stored.
  task automatic put(input logic [31:0] d, input bit accept);
    host_wvalid = 1'b1;
    host_wdata  = d;
    tick();
    host_wvalid = 1'b0;
    if (accept) exp_q.push_back(d);
  endtask

  // Monitor side: compare the offered word with the scoreboard, then consume it.
  task automatic take_narrow(input string tag);
    logic [31:0] e;
    e = exp_q.pop_front();
    check({tag, " valid"}, 64'(core_valid), 64'd1);
    check({tag, " data"}, core_data, {32'h0, e});
    core_pop = 1'b1;
    tick();
    core_pop = 1'b0;
  endtask

  task automatic take_wide(input string tag);
    logic [31:0] lo, hi;
    lo = exp_q.pop_front();
    hi = exp_q.pop_front();
    check({tag, " valid"}, 64'(core_valid), 64'd1);
    check({tag, " data"}, core_data, {hi, lo});
    core_pop = 1'b1;
    tick();
    core_pop = 1'b0;
  endtask

  task automatic start(input logic [1:0] s);
    host_start = 1'b1;
    host_sel   = s;
    tick();
    host_start = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FIFO-IF FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 req", 64'(host_req), 64'd1);
    check("R1 ack", 64'(host_ack), 64'd0);
    check("R1 en", 64'(core_en), 64'd0);
    check("R1 valid", 64'(core_valid), 64'd0);
    for (int i = 0; i < 8; i++) begin
      host_rd_addr = 3'(i);
      #1;
      check("R1 result zero", 64'(host_rd_data), 64'd0);
    end

    // R12 pop while idle consumes nothing
    put(32'hA000_0000, 1'b1);
    put(32'hA000_0001, 1'b1);
    core_pop = 1'b1;
    tick();
    core_pop = 1'b0;
    check("R12 still valid", 64'(core_valid), 64'd1);
    check("R12 head kept", core_data, {32'h0, exp_q[0]});

    // R7 / R9 narrow core 0 selected
    start(2'd0);
    check("R7 en core0", 64'(core_en), 64'b001);
    check("R9 narrow", 64'(core_wide), 64'd0);
    // R8 start while busy ignored
    start(2'd1);
    check("R8 busy start", 64'(core_en), 64'b001);

    // R2 narrow order
    take_narrow("R2 w0");
    take_narrow("R2 w1");
    check("R4 drained", 64'(core_valid), 64'd0);

    // R5 almost empty threshold
    put(32'hB000_0000, 1'b1);
    put(32'hB000_0001, 1'b1);
    put(32'hB000_0002, 1'b1);
    check("R5 at thresh", 64'(host_req), 64'd1);
    put(32'hB000_0003, 1'b1);
    check("R5 above thresh", 64'(host_req), 64'd0);
    take_narrow("R2 b0");
    check("R5 back at thresh", 64'(host_req), 64'd1);
    take_narrow("R2 b1");
    take_narrow("R2 b2");
    take_narrow("R2 b3");

    // R4 narrow turn
    put(32'hC000_0000, 1'b1);
    take_narrow("R4 c0");
    check("R4 odd turn empty", 64'(core_valid), 64'd0);
    put(32'hC000_0001, 1'b1);
    take_narrow("R4 c1");

    // R6 full drop, turn held
    for (int i = 0; i < 8; i++) put(32'hD000_0000 + 32'(i), 1'b1);
    put(32'hDEAD_BEEF, 1'b0);
    for (int i = 0; i < 8; i++) take_narrow("R6 fill");
    check("R6 dropped word absent", 64'(core_valid), 64'd0);
    put(32'hE000_0000, 1'b1);
    take_narrow("R6 turn held");
    put(32'hE000_0001, 1'b1);
    take_narrow("R6 next");

    // R11 result writes, R10 completion
    for (int i = 0; i < 8; i++) begin
      core_res_we   = 1'b1;
      core_res_addr = 3'(i);
      core_res_data = 32'h5A00_0000 + 32'(i);
      tick();
    end
    core_res_we = 1'b0;
    core_done = 1'b1;
    tick();
    core_done = 1'b0;
    check("R10 ack", 64'(host_ack), 64'd1);
    check("R10 en off", 64'(core_en), 64'd0);
    for (int i = 0; i < 8; i++) begin
      host_rd_addr = 3'(i);
      #1;
      check("R11 readback", 64'(host_rd_data), 64'(32'h5A00_0000 + 32'(i)));
    end
    core_res_we = 1'b1;
    core_res_addr = 3'd2;
    core_res_data = 32'hFFFF_FFFF;
    tick();
    core_res_we = 1'b0;
    host_rd_addr = 3'd2;
    #1;
    check("R11 idle write dropped", 64'(host_rd_data), 64'h5A00_0002);

    // R8 out-of-range select
    start(2'd3);
    check("R8 bad sel en", 64'(core_en), 64'd0);
    check("R8 bad sel ack", 64'(host_ack), 64'd1);

    // R3 / R9 wide core 1
    start(2'd1);
    check("R10 ack cleared", 64'(host_ack), 64'd0);
    check("R9 wide", 64'(core_wide), 64'd1);
    check("R7 en core1", 64'(core_en), 64'b010);
    put(32'hF000_0000, 1'b1);
    check("R3 half pair", 64'(core_valid), 64'd0);
    put(32'hF000_0001, 1'b1);
    take_wide("R3 pair0");
    check("R3 both consumed", 64'(core_valid), 64'd0);
    for (int i = 0; i < 4; i++) put(32'hF100_0000 + 32'(i), 1'b1);
    take_wide("R3 pair1");
    take_wide("R3 pair2");
    check("R3 empty", 64'(core_valid), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule